// File: doc/BRIEF.md
# Supply Supervisor with Burst Mode

This block is the supervisory state machine that sits beside a flyback pulse generator. It reads digital comparator results on the supply rail, on the line-sense input and on the regulation pin. From these it decides whether gate pulses may be issued. After each start-up it runs a timed soft-start window. When the regulation pin reports a very light load, it moves the converter into a low-power burst mode. While burst mode is active, the supply undervoltage check uses the higher of two turn-off levels, and each burst pulse is stretched to a guaranteed minimum width.

Supply overvoltage and line undervoltage do not simply drop the gate enable. They place the machine in a latched fault state. That state is left only after the supply has collapsed below the normal turn-off level, so a fault always costs a full power cycle. Line undervoltage is honoured only while the switch is off, which keeps the line-sense current that the switch itself disturbs from being misread.

The states are OFF, SOFT_START, RUN, BURST and FAULT. The transitions are:
- **power-up**: OFF to SOFT_START.
- **ramp-done**: SOFT_START to RUN.
- **burst-enter**: RUN to BURST.
- **burst-exit**: BURST to RUN.
- **brown-out**: any active state to OFF.
- **trip**: any active state to FAULT.
- **recover**: FAULT to OFF.

Top module: `supply_burst_supervisor`

## Requirements
- R1: After reset the state is OFF. gate_en_o, ss_active_o, fault_o and uv_sel_o are all 0.
- R2: In OFF, when vcc_start_i is high and vcc_uv_norm_i is low, power-up moves the machine to SOFT_START. In SOFT_START, gate_en_o and ss_active_o are 1 for exactly SS_CYC cycles. Ramp-done then moves the machine to RUN, where gate_en_o is 1 and ss_active_o is 0.
- R3: In SOFT_START and RUN, vcc_uv_norm_i high (supply below the low turn-off level) causes brown-out to OFF. In those states vcc_uv_burst_i has no effect.
- R4: In RUN, reg_low_i high causes burst-enter. In BURST, uv_sel_o is 1, and gate_en_o is 0 except during a burst pulse.
- R5: In BURST, vcc_uv_burst_i high (supply below the raised turn-off level) causes brown-out to OFF.
- R6: In BURST, a high pulse_req_i starts a burst pulse on the next edge. The pulse lasts while pulse_req_i stays high. It is never shorter than ceil(MAX_ON_CYC/7) cycles and never longer than MAX_ON_CYC cycles.
- R7: Burst-exit to RUN needs reg_low_i low on two consecutive synchronized samples. A single low sample leaves the machine in BURST.
- R8: In SOFT_START, RUN or BURST, vcc_ov_i high causes trip to FAULT. In FAULT, fault_o is 1 and gate_en_o is 0.
- R9: line_uv_i high causes trip only while ontime_i is 0. ontime_i is not synchronized, so it acts on the next edge.
- R10: FAULT ignores vcc_start_i. Recover to OFF happens only when vcc_uv_norm_i is high, and fault_o is then 0.
- R11: The six comparator inputs pass through a two-flop synchronizer. A change at one of them shows at the outputs after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_start_i | input | 1 | Supply above start level (async) |
| vcc_uv_norm_i | input | 1 | Supply below low turn-off level (async) |
| vcc_uv_burst_i | input | 1 | Supply below raised turn-off level (async) |
| vcc_ov_i | input | 1 | Supply overvoltage (async) |
| line_uv_i | input | 1 | Line-sense current too low (async) |
| reg_low_i | input | 1 | Regulation pin below burst level (async) |
| ontime_i | input | 1 | Switch on-time flip-flop state (synchronous) |
| pulse_req_i | input | 1 | Burst pulse request (synchronous) |
| gate_en_o | output | 1 | Gate pulses allowed |
| ss_active_o | output | 1 | Soft start in progress |
| fault_o | output | 1 | Latched fault |
| uv_sel_o | output | 1 | 1 selects the raised turn-off level |

## Verification
A comparator change driven on a falling edge reaches the state register on the third following rising edge. The bench therefore reads results at the falling edge after that edge. The exception is ontime_i, which the state logic uses directly, so its effect is read one edge later. Burst pulse widths are counted from the edge after pulse_req_i rises. Each check is placed one cycle before and one cycle after the boundary it targets: the soft-start length, the minimum pulse width, the maximum pulse width and the exit hysteresis.

// File: rtl/ssup_pkg.sv
package ssup_pkg;
    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_SOFT_START = 3'd1,
        ST_RUN        = 3'd2,
        ST_BURST      = 3'd3,
        ST_FAULT      = 3'd4
    } ssup_state_e;

    localparam int CMP_NUM       = 6;
    localparam int CMP_START     = 0;
    localparam int CMP_UV_NORM   = 1;
    localparam int CMP_UV_BURST  = 2;
    localparam int CMP_OV        = 3;
    localparam int CMP_LINE_UV   = 4;
    localparam int CMP_REG_LOW   = 5;
endpackage

// File: rtl/ssup_sync.sv
module ssup_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/ssup_ss_timer.sv
module ssup_ss_timer #(
    parameter int SS_CYC = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (SS_CYC > 1) ? $clog2(SS_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SS_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (!run_i)                cnt_q <= '0;
        else if (cnt_q != LAST)         cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ssup_burst_pulse.sv
module ssup_burst_pulse #(
    parameter int MAX_ON_CYC = 700,
    parameter int MIN_ON_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic req_i,
    output logic act_o
);
    localparam int CW = $clog2(MAX_ON_CYC + 1);
    localparam logic [CW-1:0] MAX_V = CW'(MAX_ON_CYC);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_ON_CYC);

    logic          act_q;
    logic [CW-1:0] len_q;
    logic          stop;

    assign stop = (len_q >= MAX_V) || ((len_q >= MIN_V) && !req_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            len_q <= '0;
        end else if (!en_i) begin
            act_q <= 1'b0;
            len_q <= '0;
        end else if (!act_q) begin
            if (req_i) begin
                act_q <= 1'b1;
                len_q <= CW'(1);
            end
        end else if (stop) begin
            act_q <= 1'b0;
            len_q <= '0;
        end else begin
            len_q <= len_q + 1'b1;
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/supply_burst_supervisor.sv
module supply_burst_supervisor
    import ssup_pkg::*;
#(
    parameter int SS_CYC     = 5_000_000,
    parameter int MAX_ON_CYC = 700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_start_i,
    input  logic vcc_uv_norm_i,
    input  logic vcc_uv_burst_i,
    input  logic vcc_ov_i,
    input  logic line_uv_i,
    input  logic reg_low_i,
    input  logic ontime_i,
    input  logic pulse_req_i,
    output logic gate_en_o,
    output logic ss_active_o,
    output logic fault_o,
    output logic uv_sel_o
);
    localparam int MIN_ON_CYC = (MAX_ON_CYC + 6) / 7;

    ssup_state_e state_q, state_d;
    logic [CMP_NUM-1:0] cmp_raw, cmp_s;
    logic ss_done, burst_act, exit_pend_q;
    logic trip, uv_active;

    assign cmp_raw[CMP_START]    = vcc_start_i;
    assign cmp_raw[CMP_UV_NORM]  = vcc_uv_norm_i;
    assign cmp_raw[CMP_UV_BURST] = vcc_uv_burst_i;
    assign cmp_raw[CMP_OV]       = vcc_ov_i;
    assign cmp_raw[CMP_LINE_UV]  = line_uv_i;
    assign cmp_raw[CMP_REG_LOW]  = reg_low_i;

    ssup_sync #(.WIDTH(CMP_NUM), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(cmp_raw), .sync_o(cmp_s)
    );

    ssup_ss_timer #(.SS_CYC(SS_CYC)) u_ss_timer (
        .clk(clk), .rst_n(rst_n),
        .run_i(state_q == ST_SOFT_START), .done_o(ss_done)
    );

    ssup_burst_pulse #(.MAX_ON_CYC(MAX_ON_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_burst (
        .clk(clk), .rst_n(rst_n),
        .en_i(state_q == ST_BURST), .req_i(pulse_req_i), .act_o(burst_act)
    );

    assign trip      = cmp_s[CMP_OV] || (cmp_s[CMP_LINE_UV] && !ontime_i);
    assign uv_active = (state_q == ST_BURST) ? cmp_s[CMP_UV_BURST] : cmp_s[CMP_UV_NORM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_OFF;
            exit_pend_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            exit_pend_q <= (state_q == ST_BURST) && !cmp_s[CMP_REG_LOW];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cmp_s[CMP_START] && !cmp_s[CMP_UV_NORM]) state_d = ST_SOFT_START;
            end
            ST_SOFT_START: begin
                if (trip)           state_d = ST_FAULT;
                else if (uv_active) state_d = ST_OFF;
                else if (ss_done)   state_d = ST_RUN;
            end
            ST_RUN: begin
                if (trip)                      state_d = ST_FAULT;
                else if (uv_active)            state_d = ST_OFF;
                else if (cmp_s[CMP_REG_LOW])   state_d = ST_BURST;
            end
            ST_BURST: begin
                if (trip)           state_d = ST_FAULT;
                else if (uv_active) state_d = ST_OFF;
                else if (exit_pend_q && !cmp_s[CMP_REG_LOW]) state_d = ST_RUN;
            end
            ST_FAULT: begin
                if (cmp_s[CMP_UV_NORM]) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        gate_en_o   = 1'b0;
        ss_active_o = 1'b0;
        fault_o     = 1'b0;
        uv_sel_o    = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_SOFT_START: begin
                gate_en_o   = 1'b1;
                ss_active_o = 1'b1;
            end
            ST_RUN:   gate_en_o = 1'b1;
            ST_BURST: begin
                gate_en_o = burst_act;
                uv_sel_o  = 1'b1;
            end
            ST_FAULT: fault_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ssup_checker.sv
module ssup_checker #(
    parameter int MIN_ON_CYC = 100,
    parameter int MAX_ON_CYC = 700
) (
    input logic clk,
    input logic rst_n,
    input logic gate_en,
    input logic ss_active,
    input logic fault,
    input logic uv_sel
);
    localparam int LW = $clog2(MAX_ON_CYC + 2);
    logic [LW-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 len_q <= '0;
        else if (gate_en && uv_sel) len_q <= len_q + 1'b1;
        else                        len_q <= '0;
    end

    AST_FAULT_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !gate_en); // R8
    AST_SS_WITH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> (gate_en && !fault && !uv_sel)); // R2
    AST_FAULT_TO_OFF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (fault || (!gate_en && !uv_sel))); // R10
    AST_BURST_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        uv_sel |-> !fault); // R4
    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_en) && uv_sel && $past(uv_sel)) |-> (len_q >= LW'(MIN_ON_CYC))); // R6
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        uv_sel |-> (len_q <= LW'(MAX_ON_CYC))); // R6
endmodule

bind supply_burst_supervisor ssup_checker #(
    .MIN_ON_CYC(MIN_ON_CYC), .MAX_ON_CYC(MAX_ON_CYC)
) u_ssup_checker (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en_o), .ss_active(ss_active_o),
    .fault(fault_o), .uv_sel(uv_sel_o)
);

// File: tb/test_supply_burst_supervisor.sv
module test_supply_burst_supervisor;
    localparam int SS_CYC = 24;
    localparam int MAX_ON = 28;
    localparam int MIN_ON = (MAX_ON + 6) / 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_start = 0, vcc_uv_norm = 0, vcc_uv_burst = 0, vcc_ov = 0;
    logic line_uv = 0, reg_low = 0, ontime = 0, pulse_req = 0;
    logic gate_en, ss_active, fault, uv_sel;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    supply_burst_supervisor #(.SS_CYC(SS_CYC), .MAX_ON_CYC(MAX_ON)) i_supply_burst_supervisor (
        .clk(clk), .rst_n(rst_n),
        .vcc_start_i(vcc_start), .vcc_uv_norm_i(vcc_uv_norm), .vcc_uv_burst_i(vcc_uv_burst),
        .vcc_ov_i(vcc_ov), .line_uv_i(line_uv), .reg_low_i(reg_low),
        .ontime_i(ontime), .pulse_req_i(pulse_req),
        .gate_en_o(gate_en), .ss_active_o(ss_active), .fault_o(fault), .uv_sel_o(uv_sel)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected outputs packed as {gate_en, ss_active, fault, uv_sel}
    task automatic expect_out(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {gate_en, ss_active, fault, uv_sel};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (gate,ss,fault,uvsel)", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        expect_out("R1 reset outputs", 4'b0000);
    endtask

    task automatic t_startup();
        vcc_start = 1;
        step(2);
        expect_out("R11 no effect before third edge", 4'b0000);
        step(1);
        expect_out("R2 R11 soft start entered", 4'b1100);
        step(SS_CYC - 1);
        expect_out("R2 still soft start at last cycle", 4'b1100);
        step(1);
        expect_out("R2 run after soft start", 4'b1000);
    endtask

    task automatic t_uv_normal();
        vcc_uv_burst = 1;
        step(4);
        expect_out("R3 raised level ignored in run", 4'b1000);
        vcc_uv_norm = 1; vcc_start = 0;
        step(3);
        expect_out("R3 brown-out to off", 4'b0000);
        vcc_uv_norm = 0; vcc_uv_burst = 0; vcc_start = 1;
        step(3 + SS_CYC);
        expect_out("R2 restart reaches run", 4'b1000);
    endtask

    task automatic t_burst();
        reg_low = 1;
        step(3);
        expect_out("R4 burst entered, gate off", 4'b0001);
        pulse_req = 1;
        step(1);
        expect_out("R6 pulse starts", 4'b1001);
        pulse_req = 0;
        step(MIN_ON - 1);
        expect_out("R6 pulse held to minimum", 4'b1001);
        step(1);
        expect_out("R6 pulse ends at minimum", 4'b0001);
        pulse_req = 1;
        step(1);
        step(MAX_ON - 1);
        expect_out("R6 long pulse still on", 4'b1001);
        step(1);
        pulse_req = 0;
        expect_out("R6 pulse cut at maximum", 4'b0001);
        reg_low = 0;
        step(1);
        reg_low = 1;
        step(5);
        expect_out("R7 single low sample ignored", 4'b0001);
        reg_low = 0;
        step(3);
        expect_out("R7 still burst after one sample", 4'b0001);
        step(1);
        expect_out("R7 exit to run", 4'b1000);
        reg_low = 1;
        step(3);
        vcc_uv_burst = 1; vcc_start = 0;
        step(3);
        expect_out("R5 raised level brown-out in burst", 4'b0000);
        vcc_uv_burst = 0; reg_low = 0; vcc_start = 1;
        step(3 + SS_CYC);
        expect_out("R2 restart after burst", 4'b1000);
    endtask

    task automatic t_faults();
        ontime = 1; line_uv = 1;
        step(5);
        expect_out("R9 line uv masked while on", 4'b1000);
        ontime = 0;
        step(1);
        expect_out("R9 line uv trips when off", 4'b0010);
        line_uv = 0;
        step(6);
        expect_out("R10 fault held, start ignored", 4'b0010);
        vcc_uv_norm = 1;
        step(3);
        expect_out("R10 recover to off", 4'b0000);
        vcc_uv_norm = 0;
        step(3 + SS_CYC);
        reg_low = 1;
        step(3);
        expect_out("R4 burst again", 4'b0001);
        vcc_ov = 1;
        step(3);
        expect_out("R8 overvoltage trip from burst", 4'b0010);
        vcc_ov = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_startup();
        t_uv_normal();
        t_burst();
        t_faults();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule